// File: doc/BRIEF.md
# Timer/Counter with Shared Prescaler

This block is an 8-bit up-counter that software preloads. It counts either instruction-cycle pulses or edges seen on an external input pin. An 8-bit prescaler can be routed to the counter to slow it down. It can instead be routed to the watchdog path, where it divides the incoming watchdog ticks. Only one of the two owns the prescaler at a time, and software has no direct access to its count. When the counter wraps from its top value to zero it sets a sticky overflow flag. An enable bit in the control word masks that flag onto the interrupt request.

The external input is not used directly. It first passes through the prescaler when the prescaler belongs to the timer. It is then sampled on two phase strobes per instruction cycle, and only a low-to-high change of that sampled level advances the counter. A write to the count clears the prescaler when the timer owns it. The write also blocks counting for the next two instruction cycles. While the sleep input is high the counter is frozen.

Control word layout (`ctl_wdata`): bits [2:0] ratio select `ps`, bit 3 prescaler owner (0 timer, 1 watchdog), bit 4 active edge (0 rising, 1 falling), bit 5 count source (0 instruction cycles, 1 external pin), bit 6 interrupt enable.

Top module: `tmr8_presc`

## Requirements
- R1: With source bit 5 = 0 and owner bit 3 = 1, `count` advances by one on each `cyc_en` pulse. It never changes by any amount other than 0 or +1 except through a count write.
- R2: With bit 5 = 1, the pin is XORed with edge bit 4 (0 counts rising edges, 1 counts falling edges). When bit 3 = 1 that value is sampled on `smp_mid`/`smp_end`, and each low-to-high change of the sampled value advances `count` in the following cycle.
- R3: A write on `cnt_wr` loads `cnt_wdata`. The counter then does not advance during the next two `cyc_en` pulses after the write cycle.
- R4: An advance from 0xFF to 0x00 sets `ovf_flag`. The flag changes otherwise only through `flag_wr`, which loads `flag_wdata` (writing 0 clears it).
- R5: `irq` is high exactly when `ovf_flag` is high and enable bit 6 is 1.
- R6: While `sleep` is high the count holds, no overflow occurs, and a timer-owned prescaler holds.
- R7: With bit 3 = 0 in internal mode, the counter advances once per 2^(ps+1) `cyc_en` pulses counted from a prescaler clear. In external mode the prescaler counts active edges, and bit ps of the prescaler is what gets sampled. The first advance therefore comes after 2^ps edges and later ones every 2^(ps+1) edges.
- R8: With bit 3 = 1, `wdt_out` pulses on every 2^ps-th `wdt_tick` counted from a clear, and the timer runs 1:1. With bit 3 = 0, `wdt_out` equals `wdt_tick`.
- R9: A count write clears the prescaler only when bit 3 = 0. `wdt_clr` clears it only when bit 3 = 1. In the other owner mode each of these has no effect on the prescaler.
- R10: If a flag write of 0 lands in the same cycle as an overflow, the flag ends up set.
- R11: After reset, `count`, `ovf_flag`, `irq` and the control word are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cyc_en | input | 1 | One-clock pulse per instruction cycle |
| smp_mid | input | 1 | Mid-cycle sampling strobe for the external input |
| smp_end | input | 1 | End-of-cycle sampling strobe for the external input |
| ext_pin | input | 1 | External count input |
| sleep | input | 1 | Freezes the timer while high |
| cnt_wr | input | 1 | Count write strobe |
| cnt_wdata | input | W | Count write data |
| ctl_wr | input | 1 | Control word write strobe |
| ctl_wdata | input | SW+4 | Control word write data |
| flag_wr | input | 1 | Overflow flag write strobe |
| flag_wdata | input | 1 | Overflow flag write value |
| wdt_clr | input | 1 | Watchdog clear strobe |
| wdt_tick | input | 1 | Watchdog base tick |
| count | output | W | Current count |
| ovf_flag | output | 1 | Sticky overflow flag |
| irq | output | 1 | Masked interrupt request |
| wdt_out | output | 1 | Watchdog postscaler tick |

## Verification
The bench uses the default widths: an 8-bit count, an 8-bit prescaler and a 3-bit ratio select. Preloading values near 0xFF therefore reaches the wrap within a few instruction cycles. Every ratio code maps onto a real prescaler bit, so the 1:8 timer ratio and the 1:8 watchdog ratio are exercised without long runs. Only a couple of pin pulses are needed to see the external prescaled phase (first advance after 2 edges, then every 4).

// File: rtl/tmr8_presc.sv
`timescale 1ns/1ps
module tmr8_presc #(
  parameter int W  = 8,
  parameter int PW = 8,
  parameter int SW = 3
)(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cyc_en,
  input  logic          smp_mid,
  input  logic          smp_end,
  input  logic          ext_pin,
  input  logic          sleep,
  input  logic          cnt_wr,
  input  logic [W-1:0]  cnt_wdata,
  input  logic          ctl_wr,
  input  logic [SW+3:0] ctl_wdata,
  input  logic          flag_wr,
  input  logic          flag_wdata,
  input  logic          wdt_clr,
  input  logic          wdt_tick,
  output logic [W-1:0]  count,
  output logic          ovf_flag,
  output logic          irq,
  output logic          wdt_out
);
  localparam int CW    = SW + 4;
  localparam int B_OWN = SW;
  localparam int B_EDG = SW + 1;
  localparam int B_SRC = SW + 2;
  localparam int B_IE  = SW + 3;

  logic [CW-1:0] ctl;
  logic [W-1:0]  cnt;
  logic [PW-1:0] pre;
  logic [1:0]    inh;
  logic          sig_d, sync_q, flag;

  wire [SW-1:0] ps   = ctl[SW-1:0];
  wire          own  = ctl[B_OWN];
  wire          edg  = ctl[B_EDG];
  wire          src  = ctl[B_SRC];
  wire          ie   = ctl[B_IE];

  wire          strobe   = smp_mid | smp_end;
  wire          sig      = ext_pin ^ edg;
  wire [PW-1:0] mask_t   = ~(({PW{1'b1}} << ps) << 1);
  wire [PW-1:0] mask_w   = ~({PW{1'b1}} << ps);
  wire          pre_out  = own ? sig : pre[ps];
  wire          ext_tick = strobe & pre_out & ~sync_q;
  wire          int_tick = cyc_en & (own | (&(pre | ~mask_t)));
  wire          adv      = (src ? ext_tick : int_tick) & ~sleep & (inh == 2'd0) & ~cnt_wr;
  wire          ovf      = adv & (&cnt);
  wire          pre_clr  = own ? wdt_clr : cnt_wr;
  wire          pre_step = own ? wdt_tick : (~sleep & (src ? (sig & ~sig_d) : cyc_en));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl    <= '0;
      cnt    <= '0;
      pre    <= '0;
      inh    <= 2'd0;
      sig_d  <= 1'b0;
      sync_q <= 1'b0;
      flag   <= 1'b0;
    end else begin
      sig_d <= sig;
      if (ctl_wr) ctl <= ctl_wdata;
      if (strobe) sync_q <= pre_out;
      if (pre_clr) pre <= '0;
      else if (pre_step) pre <= pre + PW'(1);
      if (cnt_wr) cnt <= cnt_wdata;
      else if (adv) cnt <= cnt + W'(1);
      if (cnt_wr) inh <= 2'd2;
      else if (cyc_en && inh != 2'd0) inh <= inh - 2'd1;
      if (ovf) flag <= 1'b1;
      else if (flag_wr) flag <= flag_wdata;
    end
  end

  assign count    = cnt;
  assign ovf_flag = flag;
  assign irq      = flag & ie;
  assign wdt_out  = wdt_tick & (~own | (&(pre | ~mask_w)));

  // R1: the count moves only by 0 or +1 without a write
  a_r1_step_one: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_wr |=> (count == $past(count) || count == $past(count) + W'(1)));
  // R3: inhibit window holds the count
  a_r3_inhibit_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (inh != 2'd0 && !cnt_wr) |=> $stable(count));
  // R4: a wrap without a write leaves the flag set
  a_r4_wrap_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_wr && count == {W{1'b1}}) ##1 (count == '0) |-> ovf_flag);
  // R4: the flag only drops through a flag write
  a_r4_clear_by_write: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ovf_flag) |-> $past(flag_wr));
  // R5: no request without the flag
  a_r5_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ovf_flag);
  // R6: sleep freezes the count
  a_r6_sleep_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep && !cnt_wr) |=> $stable(count));
  // R8: postscaler output only on a base tick
  a_r8_wdt_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_out |-> wdt_tick);
endmodule

// File: tb/tmr8_presc_tb.sv
`timescale 1ns/1ps
module tmr8_presc_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cyc_en = 0, smp_mid = 0, smp_end = 0, ext_pin = 0, sleep = 0;
  logic cnt_wr = 0, ctl_wr = 0, flag_wr = 0, flag_wdata = 0, wdt_clr = 0, wdt_tick = 0;
  logic [7:0] cnt_wdata = 0;
  logic [6:0] ctl_wdata = 0;
  logic [7:0] count;
  logic ovf_flag, irq, wdt_out;
  int checks = 0, fails = 0, wdt_seen = 0;
  int phase = 0;
  bit done = 0;

  always #4 clk = ~clk;

  tmr8_presc u_dut (.clk, .rst_n, .cyc_en, .smp_mid, .smp_end, .ext_pin, .sleep,
    .cnt_wr, .cnt_wdata, .ctl_wr, .ctl_wdata, .flag_wr, .flag_wdata, .wdt_clr,
    .wdt_tick, .count, .ovf_flag, .irq, .wdt_out);

  always @(posedge clk) begin
    #1;
    phase   = (phase + 1) % 4;
    smp_mid = (phase == 1);
    smp_end = (phase == 3);
    cyc_en  = (phase == 3);
  end

  // behavioural reference state
  int m_ctl, m_cnt, m_pre, m_inh, m_flag, m_sync, m_sigp;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ctl = 0; m_cnt = 0; m_pre = 0; m_inh = 0; m_flag = 0; m_sync = 0; m_sigp = 0;
    end else begin
      int ps, own, edg, src, sig, pout, tdiv, tick, adv, ovf, strobe;
      ps = m_ctl & 7; own = (m_ctl >> 3) & 1; edg = (m_ctl >> 4) & 1; src = (m_ctl >> 5) & 1;
      sig = ext_pin ^ edg;
      tdiv = 1 << (ps + 1);
      pout = own ? sig : ((m_pre >> ps) & 1);
      strobe = smp_mid | smp_end;
      if (src) tick = strobe && pout && !m_sync;
      else     tick = cyc_en && (own || (m_pre % tdiv) == tdiv - 1);
      adv = tick && !sleep && m_inh == 0 && !cnt_wr;
      ovf = adv && m_cnt == 255;
      if (own ? wdt_clr : cnt_wr) m_pre = 0;
      else if (own ? wdt_tick : (!sleep && (src ? (sig && !m_sigp) : cyc_en))) m_pre = (m_pre + 1) % 256;
      if (strobe) m_sync = pout;
      m_sigp = sig;
      if (cnt_wr) m_cnt = cnt_wdata; else if (adv) m_cnt = (m_cnt + 1) % 256;
      if (cnt_wr) m_inh = 2; else if (cyc_en && m_inh > 0) m_inh = m_inh - 1;
      if (ovf) m_flag = 1; else if (flag_wr) m_flag = flag_wdata;
      if (ctl_wr) m_ctl = ctl_wdata;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      int own, ps, ew;
      own = (m_ctl >> 3) & 1; ps = m_ctl & 7;
      ew = wdt_tick && (!own || (m_pre % (1 << ps)) == (1 << ps) - 1);
      chk("R1/R2/R3/R6/R7 count vs model", count, m_cnt);
      chk("R4/R10 flag vs model", ovf_flag, m_flag);
      chk("R5 irq vs model", irq, m_flag & ((m_ctl >> 6) & 1));
      chk("R8 wdt_out vs model", wdt_out, ew);
      if (wdt_out) wdt_seen++;
    end
  end

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) begin
      do @(posedge clk); while (!cyc_en);
    end
  endtask
  task automatic wr_cnt(input logic [7:0] v);
    @(posedge clk); #1 cnt_wr = 1; cnt_wdata = v;
    @(posedge clk); #1 cnt_wr = 0;
  endtask
  task automatic wr_ctl(input logic [6:0] v);
    @(posedge clk); #1 ctl_wr = 1; ctl_wdata = v;
    @(posedge clk); #1 ctl_wr = 0;
  endtask
  task automatic wr_flag(input logic v);
    @(posedge clk); #1 flag_wr = 1; flag_wdata = v;
    @(posedge clk); #1 flag_wr = 0;
  endtask
  task automatic pulse_pin(input int n);
    for (int i = 0; i < n; i++) begin
      ext_pin = 1; repeat (8) @(posedge clk); #1;
      ext_pin = 0; repeat (8) @(posedge clk); #1;
    end
  endtask
  task automatic wtick(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1 wdt_tick = 1;
      @(posedge clk); #1 wdt_tick = 0;
    end
  endtask
  task automatic wclr;
    @(posedge clk); #1 wdt_clr = 1;
    @(posedge clk); #1 wdt_clr = 0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    chk("R11 reset count", count, 0);
    chk("R11 reset flag", ovf_flag, 0);
    chk("R11 reset irq", irq, 0);

    // R1/R3/R4/R5: internal 1:1, ie on
    wr_ctl(7'h48);
    wr_cnt(8'hFC);
    wait_cyc(2); @(negedge clk);
    chk("R3 inhibit after write", count, 8'hFC);
    wait_cyc(4); @(negedge clk);
    chk("R1 four cycles then wrap", count, 0);
    chk("R4 flag set on wrap", ovf_flag, 1);
    chk("R5 irq with enable", irq, 1);
    wr_flag(1'b0); @(negedge clk);
    chk("R4 flag cleared by write", ovf_flag, 0);

    // R6: sleep
    sleep = 1; wr_cnt(8'hFF); wait_cyc(10); @(negedge clk);
    chk("R6 sleep holds count", count, 8'hFF);
    chk("R6 no overflow in sleep", ovf_flag, 0);
    #1 sleep = 0;

    // R7/R9: internal 1:8, watchdog clear ignored
    wr_ctl(7'h02);
    wr_cnt(8'h00);
    wait_cyc(50); wclr; wait_cyc(50); @(negedge clk);
    chk("R7/R9 internal 1:8 over 100 cycles", count, 12);
    @(posedge clk); #1 wdt_tick = 1; @(negedge clk);
    chk("R8 passthrough when timer owns prescaler", wdt_out, 1);
    @(posedge clk); #1 wdt_tick = 0;

    // R2: external rising, no prescaler
    wr_ctl(7'h28); repeat (8) @(posedge clk);
    wr_cnt(8'h00); wait_cyc(3);
    pulse_pin(10); @(negedge clk);
    chk("R2 rising edges counted", count, 10);

    // R2: external falling
    wr_ctl(7'h38); repeat (8) @(posedge clk);
    wr_cnt(8'h00); wait_cyc(3);
    #1 ext_pin = 1; repeat (12) @(posedge clk); @(negedge clk);
    chk("R2 rise ignored in falling mode", count, 0);
    #1 ext_pin = 0; repeat (12) @(posedge clk); @(negedge clk);
    chk("R2 fall counted", count, 1);

    // R7: external prescaled ps=1
    wr_ctl(7'h21); repeat (8) @(posedge clk);
    wr_cnt(8'h00); wait_cyc(3);
    pulse_pin(10); @(negedge clk);
    chk("R7 external 2 then every 4 edges", count, 3);

    // R8/R9: watchdog owns prescaler, 1:8
    wr_ctl(7'h0B); wclr;
    wdt_seen = 0; wtick(20); @(negedge clk);
    chk("R8 watchdog 1:8 over 20 ticks", wdt_seen, 2);
    wtick(5); wclr; wdt_seen = 0; wtick(7); @(negedge clk);
    chk("R9 clear restarts postscaler", wdt_seen, 0);
    wtick(1); @(negedge clk);
    chk("R9 eighth tick after clear", wdt_seen, 1);
    wr_cnt(8'h05); wdt_seen = 0; wtick(8); @(negedge clk);
    chk("R9 count write leaves watchdog prescaler", wdt_seen, 1);

    // R10: clear and overflow in the same cycle
    wr_ctl(7'h48);
    wr_cnt(8'hFF); wait_cyc(2);
    do begin @(posedge clk); #2; end while (!cyc_en);
    flag_wr = 1; flag_wdata = 0;
    @(posedge clk); #1 flag_wr = 0;
    @(negedge clk);
    chk("R10 wrap count", count, 0);
    chk("R10 overflow beats clear", ovf_flag, 1);
    wr_ctl(7'h08); @(negedge clk);
    chk("R5 irq masked", irq, 0);
    chk("R5 flag still set", ovf_flag, 1);

    repeat (10) @(posedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule